// File: doc/BRIEF.md
# Timer Register Frame with Physical and Virtual Compare Channels

This block is a 32-bit register front end for a system timer. It has one free-running 64-bit counter and two compare channels. The physical channel watches the counter directly. The virtual channel watches the counter minus a programmable 64-bit offset. Each channel drives its own interrupt output.

Software reaches the block through a simple register bus: a request strobe, a write flag, a frame select, a 12-bit byte offset and 32-bit data. Reads return data combinationally in the same cycle as the request, and writes take effect at the clock edge. The control frame (frame select 0) holds the frequency word, the identification word, the offset and three stored access words. The timer frame (frame select 1) exposes the counts as split 64-bit values, read-only mirrors of the frequency and the offset, and both channels. The counter advances by one on each `tick_i` pulse, but only after a nonzero frequency has been written.

Top module: `tmr_frame`

## Requirements
- R1: After reset every stored word is zero, both counts read zero, every channel control word reads zero and both interrupt outputs are low.
- R2: While the frequency word is zero, `tick_i` has no effect, and both the physical and the virtual count read zero at timer offsets 0x000 and 0x008.
- R3: The frequency word is written at control offset 0x000 and read back there and at timer offset 0x010. Once it is nonzero, the physical count rises by exactly one per cycle with `tick_i` high.
- R4: Writes to timer offsets 0x000, 0x004, 0x008, 0x00C, 0x010, 0x018 and 0x01C change nothing.
- R5: Offsets not listed in any requirement read zero and ignore writes, in both frames.
- R6: Control offset 0x008 reads the constant 0x0000_0002, where bit 1 flags that a virtual channel is present.
- R7: The 64-bit offset is written at control offsets 0x080 (low word) and 0x084 (high word), and is mirrored read-only at timer offsets 0x018 and 0x01C. While counting, the virtual count is the physical count minus the offset, modulo 2^64.
- R8: A read of timer offset 0x004 or 0x00C returns the high word that was captured at the most recent read of 0x000 or 0x008 respectively. The capture happens at the same edge as the low-word read, so the pair stays coherent even when a tick lands in that cycle.
- R9: Channel k (physical k=0, virtual k=1) has its compare value low word at 0x020+16k, high word at 0x024+16k, relative value at 0x028+16k and control word at 0x02C+16k. The control word holds enable in bit 0 and mask in bit 1 (both writable) and status in bit 2 (read-only). Status is 1 when the channel is enabled and its count is at or above the compare value, compared unsigned.
- R10: A channel's interrupt output equals its status AND NOT its mask.
- R11: A write to a relative-value offset sets the compare value to the current (pre-edge) count plus the sign-extended data. A read of that offset returns the low 32 bits of compare value minus count.
- R12: Control offsets 0x004 and 0x040 and timer offset 0x014 each store bits [7:0] of a write and read them back with the upper bits zero. These words have no other effect.
- R13: The physical channel compares against the physical count and drives `irq_phys_o`. The virtual channel compares against the virtual count and drives `irq_virt_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance pulse |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| frame_i | input | 1 | 0 = control frame, 1 = timer frame |
| addr_i | input | 12 | Byte offset within the frame |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while a read is requested |
| irq_phys_o | output | 1 | Physical channel interrupt |
| irq_virt_o | output | 1 | Virtual channel interrupt |

## Verification
Two pairs of events can share one cycle. The first pair is a counter tick and a relative-value write: the bench issues both in the same cycle and expects the compare value to be the pre-edge count plus the data, and the relative readback to be one lower. The second pair is a counter tick and a low-word count read: the offset is set so that the virtual count sits at all ones. The bench then reads the virtual low word with a tick in the same cycle and expects the following high-word read to return the pre-carry all-ones value, not the rolled-over zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int AW   = 12;
  localparam int DW   = 32;
  localparam int CW   = 64;
  localparam int ACW  = 8;
  localparam int CH_N = 2;

  // control frame
  localparam logic [AW-1:0] C_FREQ    = 12'h000;
  localparam logic [AW-1:0] C_NSA     = 12'h004;
  localparam logic [AW-1:0] C_ID      = 12'h008;
  localparam logic [AW-1:0] C_ACR     = 12'h040;
  localparam logic [AW-1:0] C_VOFF_LO = 12'h080;
  localparam logic [AW-1:0] C_VOFF_HI = 12'h084;
  // timer frame
  localparam logic [AW-1:0] T_PCT_LO  = 12'h000;
  localparam logic [AW-1:0] T_PCT_HI  = 12'h004;
  localparam logic [AW-1:0] T_VCT_LO  = 12'h008;
  localparam logic [AW-1:0] T_VCT_HI  = 12'h00C;
  localparam logic [AW-1:0] T_FREQ    = 12'h010;
  localparam logic [AW-1:0] T_UACR    = 12'h014;
  localparam logic [AW-1:0] T_VOFF_LO = 12'h018;
  localparam logic [AW-1:0] T_VOFF_HI = 12'h01C;
  localparam int CH_BASE   = 'h20;
  localparam int CH_STRIDE = 'h10;

  localparam logic [DW-1:0] ID_WORD = 32'h0000_0002;

  typedef enum logic [1:0] {
    SLOT_CV_LO = 2'd0,
    SLOT_CV_HI = 2'd1,
    SLOT_REL   = 2'd2,
    SLOT_CTL   = 2'd3
  } ch_slot_e;

  function automatic logic [AW-1:0] ch_addr(input int ch, input ch_slot_e slot);
    return AW'(CH_BASE + ch * CH_STRIDE + 4 * int'(slot));
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_o <= '0;
    else if (run_i && tick_i) cnt_o <= cnt_o + 1'b1;
  end

  AST_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(run_i && tick_i) |=> $stable(cnt_o)); // R2
  AST_STEP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i) |=> cnt_o == $past(cnt_o) + 1'b1); // R3
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CW = 64,
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] count_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic          we_rel_i,
  input  logic          we_ctl_i,
  output logic [CW-1:0] cval_o,
  output logic [DW-1:0] rel_o,
  output logic [DW-1:0] ctl_o,
  output logic          irq_o
);
  logic en_q, mask_q, status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cval_o <= '0;
      en_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      if (we_lo_i)  cval_o[DW-1:0]  <= wdata_i;
      if (we_hi_i)  cval_o[CW-1:DW] <= wdata_i[CW-DW-1:0];
      if (we_rel_i) cval_o <= count_i + {{(CW-DW){wdata_i[DW-1]}}, wdata_i};
      if (we_ctl_i) begin
        en_q   <= wdata_i[0];
        mask_q <= wdata_i[1];
      end
    end
  end

  assign status = en_q && (count_i >= cval_o);
  assign rel_o  = cval_o[DW-1:0] - count_i[DW-1:0];
  assign ctl_o  = {{(DW-3){1'b0}}, status, mask_q, en_q};
  assign irq_o  = status && !mask_q;

  AST_REL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_rel_i |=> cval_o == $past(count_i) + {{(CW-DW){$past(wdata_i[DW-1])}}, $past(wdata_i)}); // R11
  AST_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_o[1] |-> !irq_o); // R10
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctl_o[0] && ctl_o[2]); // R9
endmodule

// File: rtl/tmr_frame.sv
module tmr_frame
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          frame_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_phys_o,
  output logic          irq_virt_o
);
  logic            wr, rd, run;
  logic [DW-1:0]   freq_q;
  logic [ACW-1:0]  nsa_q, acr_q, uacr_q;
  logic [CW-1:0]   voff_q, cnt, pct, vct;
  logic [DW-1:0]   snap_p_q, snap_v_q;
  logic [CW-1:0]   ch_cnt  [CH_N];
  logic [CW-1:0]   ch_cval [CH_N];
  logic [DW-1:0]   ch_rel  [CH_N];
  logic [DW-1:0]   ch_ctl  [CH_N];
  logic [CH_N-1:0] ch_irq;

  assign wr  = req_i && we_i;
  assign rd  = req_i && !we_i;
  assign run = (freq_q != '0);
  assign pct = run ? cnt : '0;
  assign vct = run ? (cnt - voff_q) : '0;
  assign ch_cnt[0] = pct;
  assign ch_cnt[1] = vct;

  tmr_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni, .run_i(run), .tick_i, .cnt_o(cnt)
  );

  for (genvar g = 0; g < CH_N; g++) begin : g_ch
    logic hit_t;
    assign hit_t = wr && frame_i;
    tmr_channel #(.CW(CW), .DW(DW)) u_ch (
      .clk_i, .rst_ni,
      .count_i (ch_cnt[g]),
      .wdata_i,
      .we_lo_i (hit_t && addr_i == ch_addr(g, SLOT_CV_LO)),
      .we_hi_i (hit_t && addr_i == ch_addr(g, SLOT_CV_HI)),
      .we_rel_i(hit_t && addr_i == ch_addr(g, SLOT_REL)),
      .we_ctl_i(hit_t && addr_i == ch_addr(g, SLOT_CTL)),
      .cval_o  (ch_cval[g]),
      .rel_o   (ch_rel[g]),
      .ctl_o   (ch_ctl[g]),
      .irq_o   (ch_irq[g])
    );
  end

  assign irq_phys_o = ch_irq[0];
  assign irq_virt_o = ch_irq[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      freq_q   <= '0;
      nsa_q    <= '0;
      acr_q    <= '0;
      uacr_q   <= '0;
      voff_q   <= '0;
      snap_p_q <= '0;
      snap_v_q <= '0;
    end else begin
      if (wr && !frame_i) begin
        case (addr_i)
          C_FREQ:    freq_q           <= wdata_i;
          C_NSA:     nsa_q            <= wdata_i[ACW-1:0];
          C_ACR:     acr_q            <= wdata_i[ACW-1:0];
          C_VOFF_LO: voff_q[DW-1:0]   <= wdata_i;
          C_VOFF_HI: voff_q[CW-1:DW]  <= wdata_i[CW-DW-1:0];
          default: ;
        endcase
      end
      if (wr && frame_i && addr_i == T_UACR) uacr_q <= wdata_i[ACW-1:0];
      // high words captured with the low-word read for coherent pairs
      if (rd && frame_i && addr_i == T_PCT_LO) snap_p_q <= pct[CW-1:DW];
      if (rd && frame_i && addr_i == T_VCT_LO) snap_v_q <= vct[CW-1:DW];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd && !frame_i) begin
      case (addr_i)
        C_FREQ:    rdata_o = freq_q;
        C_NSA:     rdata_o = DW'(nsa_q);
        C_ID:      rdata_o = ID_WORD;
        C_ACR:     rdata_o = DW'(acr_q);
        C_VOFF_LO: rdata_o = voff_q[DW-1:0];
        C_VOFF_HI: rdata_o = voff_q[CW-1:DW];
        default: ;
      endcase
    end else if (rd && frame_i) begin
      case (addr_i)
        T_PCT_LO:  rdata_o = pct[DW-1:0];
        T_PCT_HI:  rdata_o = snap_p_q;
        T_VCT_LO:  rdata_o = vct[DW-1:0];
        T_VCT_HI:  rdata_o = snap_v_q;
        T_FREQ:    rdata_o = freq_q;
        T_UACR:    rdata_o = DW'(uacr_q);
        T_VOFF_LO: rdata_o = voff_q[DW-1:0];
        T_VOFF_HI: rdata_o = voff_q[CW-1:DW];
        default: ;
      endcase
      for (int c = 0; c < CH_N; c++) begin
        if (addr_i == ch_addr(c, SLOT_CV_LO)) rdata_o = ch_cval[c][DW-1:0];
        if (addr_i == ch_addr(c, SLOT_CV_HI)) rdata_o = ch_cval[c][CW-1:DW];
        if (addr_i == ch_addr(c, SLOT_REL))   rdata_o = ch_rel[c];
        if (addr_i == ch_addr(c, SLOT_CTL))   rdata_o = ch_ctl[c];
      end
    end
  end

  AST_RO_FREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && frame_i) |=> $stable(freq_q)); // R4
  AST_RO_VOFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && frame_i) |=> $stable(voff_q)); // R4
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |-> (pct == '0 && vct == '0)); // R2
  AST_READ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |-> rdata_o == '0); // R5
endmodule

// File: tb/tb_tmr_frame.sv
module tb_tmr_frame;
  logic        clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, frame_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        irq_phys_o, irq_virt_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tmr_frame dut (.*);

  // entry: {req[3:0], we, frame, addr[11:0], data[31:0]}; data is wdata or expected read
  localparam int NV = 32;
  localparam logic [49:0] VEC [NV] = '{
    {4'd1,  1'b0, 1'b0, 12'h000, 32'h0},          // R1 freq
    {4'd1,  1'b0, 1'b1, 12'h000, 32'h0},          // R1 count
    {4'd1,  1'b0, 1'b1, 12'h02C, 32'h0},          // R1 ctl
    {4'd6,  1'b0, 1'b0, 12'h008, 32'h2},          // R6
    {4'd12, 1'b1, 1'b0, 12'h004, 32'hFFFF_FFA5},
    {4'd12, 1'b0, 1'b0, 12'h004, 32'hA5},         // R12
    {4'd12, 1'b1, 1'b0, 12'h040, 32'h3C},
    {4'd12, 1'b0, 1'b0, 12'h040, 32'h3C},         // R12
    {4'd12, 1'b1, 1'b1, 12'h014, 32'h103},
    {4'd12, 1'b0, 1'b1, 12'h014, 32'h03},         // R12
    {4'd5,  1'b1, 1'b0, 12'h0C0, 32'h1234},
    {4'd5,  1'b0, 1'b0, 12'h0C0, 32'h0},          // R5
    {4'd5,  1'b0, 1'b1, 12'h044, 32'h0},          // R5
    {4'd7,  1'b1, 1'b0, 12'h080, 32'h10},
    {4'd7,  1'b1, 1'b0, 12'h084, 32'h0},
    {4'd7,  1'b0, 1'b1, 12'h018, 32'h10},         // R7 mirror
    {4'd4,  1'b1, 1'b1, 12'h018, 32'h99},
    {4'd4,  1'b0, 1'b0, 12'h080, 32'h10},         // R4 mirror write ignored
    {4'd4,  1'b1, 1'b1, 12'h010, 32'h55},
    {4'd4,  1'b0, 1'b0, 12'h000, 32'h0},          // R4 freq mirror write ignored
    {4'd3,  1'b1, 1'b0, 12'h000, 32'd100},
    {4'd3,  1'b0, 1'b1, 12'h010, 32'd100},        // R3
    {4'd2,  1'b0, 1'b1, 12'h000, 32'h0},          // R2 no ticks kept while off
    {4'd9,  1'b1, 1'b1, 12'h020, 32'h5},
    {4'd9,  1'b1, 1'b1, 12'h024, 32'h0},
    {4'd9,  1'b0, 1'b1, 12'h020, 32'h5},          // R9
    {4'd9,  1'b0, 1'b1, 12'h024, 32'h0},          // R9
    {4'd11, 1'b0, 1'b1, 12'h028, 32'h5},          // R11
    {4'd7,  1'b0, 1'b1, 12'h008, 32'hFFFF_FFF0},  // R7 0 - 0x10
    {4'd8,  1'b0, 1'b1, 12'h00C, 32'hFFFF_FFFF},  // R8
    {4'd4,  1'b1, 1'b1, 12'h000, 32'hDEAD},
    {4'd4,  1'b0, 1'b1, 12'h000, 32'h0}           // R4 count write ignored
  };

  task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic op(input logic w, input logic f, input logic [11:0] a,
                    input logic [31:0] d, input logic t, output logic [31:0] r);
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; frame_i = f; addr_i = a; wdata_i = d; tick_i = t;
    #1 r = rdata_o;
    @(posedge clk_i);
    #1 req_i = 1'b0; we_i = 1'b0; tick_i = 1'b0;
  endtask

  task automatic wr(input logic f, input logic [11:0] a, input logic [31:0] d);
    logic [31:0] r;
    op(1'b1, f, a, d, 1'b0, r);
  endtask

  task automatic rd(input int q, input logic f, input logic [11:0] a, input logic [31:0] e);
    logic [31:0] r;
    op(1'b0, f, a, 32'h0, 1'b0, r);
    check(q, r, e);
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); tick_i = 1'b1;
      @(posedge clk_i); #1 tick_i = 1'b0;
    end
  endtask

  initial begin
    logic [31:0] r;
    #10 rst_ni = 1'b1;
    @(negedge clk_i);
    check(1, {30'b0, irq_virt_o, irq_phys_o}, 32'h0);   // R1 irqs low
    tk(5);                                             // R2 ticks while off
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][45]) wr(VEC[i][44], VEC[i][43:32], VEC[i][31:0]);
      else            rd(int'(VEC[i][49:46]), VEC[i][44], VEC[i][43:32], VEC[i][31:0]);
    end
    // R3 counting
    tk(3);
    rd(3, 1'b1, 12'h000, 32'd3);
    rd(8, 1'b1, 12'h004, 32'd0);
    // R9 / R10 physical compare at 5
    wr(1'b1, 12'h02C, 32'h1);
    rd(9, 1'b1, 12'h02C, 32'h1);
    @(negedge clk_i); check(10, {31'b0, irq_phys_o}, 32'h0);
    tk(2);
    rd(9, 1'b1, 12'h02C, 32'h5);
    @(negedge clk_i); check(10, {31'b0, irq_phys_o}, 32'h1);
    wr(1'b1, 12'h02C, 32'h3);
    rd(10, 1'b1, 12'h02C, 32'h7);
    @(negedge clk_i); check(10, {31'b0, irq_phys_o}, 32'h0);
    // R11 negative relative load at count 5
    wr(1'b1, 12'h028, 32'hFFFF_FFFE);
    rd(11, 1'b1, 12'h020, 32'd3);
    rd(11, 1'b1, 12'h028, 32'hFFFF_FFFE);
    // R11 relative write and tick in the same cycle: pre-edge count 5
    op(1'b1, 1'b1, 12'h028, 32'd10, 1'b1, r);
    rd(11, 1'b1, 12'h020, 32'd15);
    rd(11, 1'b1, 12'h028, 32'd9);
    // R7 / R8 virtual count at all ones, low read coincides with tick
    wr(1'b0, 12'h080, 32'd7);                          // count 6 -> virtual -1
    op(1'b0, 1'b1, 12'h008, 32'h0, 1'b1, r);
    check(7, r, 32'hFFFF_FFFF);
    rd(8, 1'b1, 12'h00C, 32'hFFFF_FFFF);               // snapshot, not rolled
    rd(7, 1'b1, 12'h008, 32'h0);
    rd(8, 1'b1, 12'h00C, 32'h0);
    // R13 virtual channel compares against virtual count
    wr(1'b1, 12'h030, 32'd2);
    wr(1'b1, 12'h034, 32'd0);
    wr(1'b1, 12'h03C, 32'h1);
    @(negedge clk_i); check(13, {30'b0, irq_virt_o, irq_phys_o}, 32'h0);
    tk(2);
    @(negedge clk_i); check(13, {30'b0, irq_virt_o, irq_phys_o}, 32'h2);
    rd(13, 1'b1, 12'h03C, 32'h5);
    // R2 turning the counter off
    wr(1'b0, 12'h000, 32'h0);
    rd(2, 1'b1, 12'h000, 32'h0);
    rd(2, 1'b1, 12'h008, 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R0 watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule